// File: doc/BRIEF.md
# Watchdog Timer with Selectable Expiry Actions

This block is a supervisory counter for a single-board controller. Software sets a timeout period and then arms the watchdog through a small register interface. From then on it must write the service register before the period runs out. The period is counted in ticks of a fixed clock prescaler. If the counter expires, a sticky timeout flag is latched and up to three actions follow.

The three actions are separate. A one-cycle system reset request is issued only when a static board strap input allows it, and software has no way to override the strap. A non-maskable interrupt request has its own software enable. A backplane failure indication has another software enable. The interrupt and failure outputs are levels that hold until software clears the timeout flag. Once the watchdog is armed, only a hardware reset disarms it. A stray write therefore cannot switch it off.

Register map, selected by the 2-bit register address:
- 0: control. Bit 0 arms the watchdog, bit 1 enables the interrupt action, bit 2 enables the failure action.
- 1: period, in prescaler ticks.
- 2: service. Any write to it reloads the counter.
- 3: status. Bit 0 is the timeout flag.

Top module: `wdog_unit`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0, the period register reads INIT_PERIOD, and all three action outputs are low.
- R2: While the watchdog is not armed, no timeout occurs, however long the wait.
- R3: Writing 1 to control bit 0 arms the watchdog and loads the period. The status flag (status bit 0) becomes 1 exactly PERIOD×PRESCALE clock cycles after the arming write.
- R4: Once armed, the watchdog stays armed until hardware reset. Writing 0 to control bit 0 leaves bit 0 reading 1, neither reloads nor stops the count, and the timeout still occurs on schedule.
- R5: Any write to address 2 restarts both the prescaler and the counter from the full period. A service write in the same cycle as the final tick prevents that timeout.
- R6: On each timeout, wd_reset_req is high for exactly one cycle, and only if reset_strap was high at the expiring edge. The strap has no effect on the other actions.
- R7: wd_nmi_req is high while the status flag is set and control bit 1 is 1.
- R8: wd_fail_req is high while the status flag is set and control bit 2 is 1.
- R9: Writing 1 to status bit 0 clears the flag, and writing 0 leaves it unchanged. A new timeout in the same cycle as a clear leaves the flag set.
- R10: A period value of 0 behaves as a period of 1 tick.
- R11: After a timeout, the counter reloads and keeps running. A further timeout follows one period later if there is no service write, and it raises wd_reset_req again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable, qualified by bus_sel |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | PERIOD_W | Write data |
| bus_rdata | output | PERIOD_W | Read data for bus_addr (combinational) |
| reset_strap | input | 1 | Board strap that permits the reset action |
| wd_reset_req | output | 1 | One-cycle reset request on timeout |
| wd_nmi_req | output | 1 | Non-maskable interrupt request level |
| wd_fail_req | output | 1 | Backplane failure indication level |

## Verification
Two pairs of events can fall on the same clock edge. The first pair is a service write and the final tick of the count. The bench places a service write on exactly the edge where expiry is due, then checks that the flag stays clear and that the next timeout comes a full period later. The second pair is a status clear and a fresh expiry. The bench lets the free-running counter expire again and issues a write-1 clear on that same edge, then judges by reading the flag back as set and by seeing the reset pulse.

// File: rtl/wdog_pkg.sv
`timescale 1ns/100ps
package wdog_pkg;

    typedef enum logic [1:0] {
        REG_CTRL    = 2'd0,
        REG_PERIOD  = 2'd1,
        REG_SERVICE = 2'd2,
        REG_STATUS  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic fail_en;
        logic nmi_en;
        logic armed;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic int cnt_width(input int n);
        return (n > 2) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wdog_prescale.sv
`timescale 1ns/100ps
module wdog_prescale
    import wdog_pkg::*;
#(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int CW = cnt_width(PRESCALE);
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

    logic [CW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = run && !restart && (div_q == LAST);
endmodule

// File: rtl/wdog_counter.sv
`timescale 1ns/100ps
module wdog_counter #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic                load,
    input  logic                tick,
    input  logic [PERIOD_W-1:0] period,
    output logic                expire
);
    logic [PERIOD_W-1:0] remain_q;
    logic [PERIOD_W-1:0] reload_val;
    logic                last_tick;

    assign reload_val = (period == '0) ? PERIOD_W'(1) : period;
    assign last_tick  = (remain_q <= PERIOD_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= reload_val;
        end else if (tick) begin
            remain_q <= last_tick ? reload_val : remain_q - 1'b1;
        end
    end

    assign expire = run && tick && !load && last_tick;
endmodule

// File: rtl/wdog_regs.sv
`timescale 1ns/100ps
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int PERIOD_W = 16,
    parameter logic [PERIOD_W-1:0] INIT_PERIOD = '1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [1:0]          bus_addr,
    input  logic [PERIOD_W-1:0] bus_wdata,
    output logic [PERIOD_W-1:0] bus_rdata,
    input  logic                expire,
    output ctrl_t               ctrl,
    output logic [PERIOD_W-1:0] period,
    output logic                timeout,
    output logic                load
);
    logic  wr;
    logic  arm_start;
    logic  kick;
    ctrl_t ctrl_q;
    logic  [PERIOD_W-1:0] period_q;
    logic  timeout_q;

    assign wr        = bus_sel && bus_we;
    assign kick      = wr && (bus_addr == REG_SERVICE);
    assign arm_start = wr && (bus_addr == REG_CTRL) && bus_wdata[0] && !ctrl_q.armed;
    assign load      = kick || arm_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            period_q  <= INIT_PERIOD;
            timeout_q <= 1'b0;
        end else begin
            if (wr && bus_addr == REG_CTRL) begin
                ctrl_q.armed   <= ctrl_q.armed | bus_wdata[0];
                ctrl_q.nmi_en  <= bus_wdata[1];
                ctrl_q.fail_en <= bus_wdata[2];
            end
            if (wr && bus_addr == REG_PERIOD) begin
                period_q <= bus_wdata;
            end
            if (expire) begin
                timeout_q <= 1'b1;
            end else if (wr && bus_addr == REG_STATUS && bus_wdata[0]) begin
                timeout_q <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (reg_addr_e'(bus_addr))
            REG_CTRL:   bus_rdata = PERIOD_W'(ctrl_q);
            REG_PERIOD: bus_rdata = period_q;
            REG_STATUS: bus_rdata = PERIOD_W'(timeout_q);
            default:    bus_rdata = '0;
        endcase
    end

    assign ctrl    = ctrl_q;
    assign period  = period_q;
    assign timeout = timeout_q;
endmodule

// File: rtl/wdog_unit.sv
`timescale 1ns/100ps
module wdog_unit
    import wdog_pkg::*;
#(
    parameter int PERIOD_W = 16,
    parameter int PRESCALE = 1024,
    parameter logic [PERIOD_W-1:0] INIT_PERIOD = PERIOD_W'(1000)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [1:0]          bus_addr,
    input  logic [PERIOD_W-1:0] bus_wdata,
    output logic [PERIOD_W-1:0] bus_rdata,
    input  logic                reset_strap,
    output logic                wd_reset_req,
    output logic                wd_nmi_req,
    output logic                wd_fail_req
);
    ctrl_t               ctrl;
    logic [PERIOD_W-1:0] period;
    logic                timeout_q;
    logic                load;
    logic                tick;
    logic                expire;
    logic                rst_pulse_q;

    wdog_regs #(.PERIOD_W(PERIOD_W), .INIT_PERIOD(INIT_PERIOD)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .expire    (expire),
        .ctrl      (ctrl),
        .period    (period),
        .timeout   (timeout_q),
        .load      (load)
    );

    wdog_prescale #(.PRESCALE(PRESCALE)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl.armed),
        .restart (load),
        .tick    (tick)
    );

    wdog_counter #(.PERIOD_W(PERIOD_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run    (ctrl.armed),
        .load   (load),
        .tick   (tick),
        .period (period),
        .expire (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_pulse_q <= 1'b0;
        end else begin
            rst_pulse_q <= expire && reset_strap;
        end
    end

    assign wd_reset_req = rst_pulse_q;
    assign wd_nmi_req   = timeout_q && ctrl.nmi_en;
    assign wd_fail_req  = timeout_q && ctrl.fail_en;
endmodule

// File: rtl/wdog_unit_chk.sv
`timescale 1ns/100ps
module wdog_unit_chk (
    input logic clk,
    input logic rst,
    input logic armed,
    input logic timeout_q,
    input logic load,
    input logic reset_strap,
    input logic wd_reset_req
);
    // R4: arming is sticky until reset
    p_arm_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        $past(armed) |-> armed);

    // R2: the flag can only rise while armed
    p_no_timeout_unarmed_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_q) |-> armed);

    // R5: a reload with a clear flag cannot expire on the next edge
    p_service_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (load && !timeout_q) |=> !timeout_q);

    // R6: the reset pulse follows the strap sampled at the expiring edge
    p_reset_strap_r6: assert property (@(posedge clk) disable iff (rst)
        wd_reset_req |-> $past(reset_strap));

    // R6: the reset request lasts one cycle
    p_reset_single_r6: assert property (@(posedge clk) disable iff (rst)
        wd_reset_req |=> !wd_reset_req);
endmodule

bind wdog_unit wdog_unit_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .armed        (ctrl.armed),
    .timeout_q    (timeout_q),
    .load         (load),
    .reset_strap  (reset_strap),
    .wd_reset_req (wd_reset_req)
);

// File: tb/wdog_unit_test.sv
`timescale 1ns/100ps
module wdog_unit_test;
    localparam int PW    = 16;
    localparam int PS    = 4;
    localparam int INITP = 77;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [1:0]    bus_addr = 2'd0;
    logic [PW-1:0] bus_wdata = '0;
    logic [PW-1:0] bus_rdata;
    logic          reset_strap = 1'b0;
    logic          wd_reset_req, wd_nmi_req, wd_fail_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wdog_unit #(.PERIOD_W(PW), .PRESCALE(PS), .INIT_PERIOD(PW'(INITP))) uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .reset_strap(reset_strap), .wd_reset_req(wd_reset_req),
        .wd_nmi_req(wd_nmi_req), .wd_fail_req(wd_fail_req)
    );

    // vector: {period[15:0], strap, nmi_en, fail_en}
    localparam logic [18:0] VEC [0:3] = '{
        {16'd1, 1'b1, 1'b0, 1'b0},
        {16'd2, 1'b0, 1'b1, 1'b0},
        {16'd3, 1'b1, 1'b1, 1'b1},
        {16'd5, 1'b0, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [PW-1:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [PW-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic waitn(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        waitn(3);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        logic [PW-1:0] rv;
        @(negedge clk);
        do_reset();

        // R1 reset state
        rd(2'd0, rv); chk("R1 ctrl", 32'(rv), 0);
        rd(2'd3, rv); chk("R1 status", 32'(rv), 0);
        rd(2'd1, rv); chk("R1 period", 32'(rv), INITP);
        chk("R1 outputs", {29'd0, wd_reset_req, wd_nmi_req, wd_fail_req}, 0);

        // R2 unarmed: no timeout
        reset_strap = 1'b1;
        wr(2'd1, 16'd1);
        wr(2'd0, 16'h0006);
        waitn(40);
        rd(2'd3, rv); chk("R2 status unarmed", 32'(rv), 0);
        chk("R2 actions unarmed", {29'd0, wd_reset_req, wd_nmi_req, wd_fail_req}, 0);

        // R3 R6 R7 R8: vector table
        for (int v = 0; v < 4; v++) begin
            int n;
            logic s, ne, fe;
            n  = int'(VEC[v][18:3]);
            s  = VEC[v][2];
            ne = VEC[v][1];
            fe = VEC[v][0];
            do_reset();
            reset_strap = s;
            wr(2'd1, PW'(n));
            wr(2'd0, {13'd0, fe, ne, 1'b1});
            waitn(n * PS - 1);
            rd(2'd3, rv); chk("R3 no early timeout", 32'(rv), 0);
            chk("R6 no early reset", 32'(wd_reset_req), 0);
            waitn(1);
            rd(2'd3, rv); chk("R3 timeout on time", 32'(rv), 1);
            chk("R6 reset follows strap", 32'(wd_reset_req), 32'(s));
            chk("R7 nmi action", 32'(wd_nmi_req), 32'(ne));
            chk("R8 fail action", 32'(wd_fail_req), 32'(fe));
            waitn(1);
            chk("R6 reset one cycle", 32'(wd_reset_req), 0);
            wr(2'd3, 16'd1);
            chk("R7 nmi drops on clear", 32'(wd_nmi_req), 0);
            chk("R8 fail drops on clear", 32'(wd_fail_req), 0);
        end

        // R4 arm is sticky
        do_reset();
        reset_strap = 1'b0;
        wr(2'd1, 16'd2);
        wr(2'd0, 16'h0001);
        wr(2'd0, 16'h0000);
        rd(2'd0, rv); chk("R4 arm bit stays", 32'(rv[0]), 1);
        waitn(6);
        rd(2'd3, rv); chk("R4 no early timeout", 32'(rv), 0);
        waitn(1);
        rd(2'd3, rv); chk("R4 timeout despite disarm write", 32'(rv), 1);

        // R5 service on the expiring edge, then R9 and R11
        do_reset();
        reset_strap = 1'b1;
        wr(2'd1, 16'd3);
        wr(2'd0, 16'h0001);
        waitn(11);
        wr(2'd2, 16'h0000);
        rd(2'd3, rv); chk("R5 same-cycle service prevents timeout", 32'(rv), 0);
        chk("R5 no reset pulse", 32'(wd_reset_req), 0);
        waitn(11);
        rd(2'd3, rv); chk("R5 full period after service", 32'(rv), 0);
        waitn(1);
        rd(2'd3, rv); chk("R5 timeout after period", 32'(rv), 1);
        wr(2'd3, 16'd0);
        rd(2'd3, rv); chk("R9 write 0 keeps flag", 32'(rv), 1);
        wr(2'd3, 16'd1);
        rd(2'd3, rv); chk("R9 write 1 clears flag", 32'(rv), 0);
        waitn(9);
        wr(2'd3, 16'd1);
        rd(2'd3, rv); chk("R9 set wins over clear", 32'(rv), 1);
        chk("R11 second timeout reset pulse", 32'(wd_reset_req), 1);

        // R10 period 0 acts as 1
        do_reset();
        wr(2'd1, 16'd0);
        wr(2'd0, 16'h0001);
        waitn(PS - 1);
        rd(2'd3, rv); chk("R10 no early timeout", 32'(rv), 0);
        waitn(1);
        rd(2'd3, rv); chk("R10 zero period expires in one tick", 32'(rv), 1);

        finish_run();
    end
endmodule